// File: doc/BRIEF.md
# PCIe Link-Up Monitor with Stalled-Speed-Change Recovery

This block watches two 32-bit debug status words from a PCIe controller and turns them into a clean, registered link-up flag. The link counts as up only when the "link established" bit of the second word is set and that word's "training in progress" bit is clear.

While the link stays down, a timer runs. When it expires, the block reads the PHY's receive-valid register through an indirect PHY register port. A separate access engine outside this block serves that port. The block then compares the LTSSM state in the first debug word with the receiver-lock recovery encoding. If the LTSSM is in that state and receive-valid is zero, a speed change has stalled.

To recover, the block reads the PHY receive-override register, writes it back with the data-enable and PLL-enable override bits set, reads it again, and writes it back with those bits cleared. It raises a one-cycle stuck pulse when the sequence starts. An error response at any step ends the sequence and sets a sticky error flag.

The register port has two channels. The request channel is valid/ready: the block holds a request and its fields steady until the engine takes it. The response channel offers `rsp_ready` only while a response is awaited, and a response is taken in a cycle where both `rsp_valid` and `rsp_ready` are high. At most one access is outstanding at any time.

Top module: `pcie_link_watch`

## Requirements
- R1: `link_up` equals (debug word 1 bit 4 AND NOT debug word 1 bit 29), registered, so it follows the word one clock edge later.
- R2: A probe request is issued exactly WAIT_CYCLES edges after `link_up` falls. No probe is issued while `link_up` is high.
- R3: A probe is a read (`req_write`=0) of PHY address 16'h100D.
- R4: When the probe response arrives, a stall is declared only if debug word 0 bits [5:0] equal RCVR_LOCK (default 6'h0D) and the response data is 16'h0000. Otherwise the block returns to idle with no further access.
- R5: The recovery sequence has four accesses in this order:
  - read 16'h1005, returning value A;
  - write A | 16'h0028 to 16'h1005 (bit 5 is the data-enable override, bit 3 the PLL-enable override);
  - read 16'h1005, returning value B;
  - write B & ~16'h0028 to 16'h1005.
- R6: `stuck_pulse` is high for exactly one cycle per recovery sequence, in the first cycle that the read request for 16'h1005 is presented.
- R7: A response with `rsp_err`=1 ends the sequence with no further access in that sequence. `err_flag` is set and stays set until reset.
- R8: A request whose `req_valid` is high holds its valid, address, write and data fields stable until `req_ready`. `rsp_ready` is high only while a response is awaited, and never in the same cycle as `req_valid`.
- R9: After reset, `link_up`, `stuck_pulse`, `err_flag`, `req_valid` and `rsp_ready` are 0.
- R10: After a probe that finds no stall, or after a finished or aborted sequence, the timer restarts, so probes repeat while the link stays down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_word0 | input | DBG_W | Debug word 0; bits [LTSSM_W-1:0] hold the LTSSM state |
| dbg_word1 | input | DBG_W | Debug word 1; link bit UP_BIT, training bit TRAIN_BIT |
| link_up | output | 1 | Qualified link-up flag |
| stuck_pulse | output | 1 | One-cycle pulse when a recovery sequence starts |
| err_flag | output | 1 | Sticky flag for a port error |
| req_valid | output | 1 | PHY access request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | PHY register address |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Block awaits a response |
| rsp_data | input | DATA_W | Read data |
| rsp_err | input | 1 | Access failed |

## Verification
`link_up` changes one clock edge after a debug word changes. The first probe request appears exactly WAIT_CYCLES edges after `link_up` drops. `stuck_pulse` coincides with the first override-register read request. The bench drives inputs on falling edges and samples on the following falling edge, so each result is checked half a cycle after the edge that produces it. The probe delay is measured by counting falling edges from the first one that shows `link_up` low. A scoreboard queue holds each expected access; the emulated port engine compares every accepted request in order and adds back-pressure, so only the order and contents of accesses are checked, not their absolute cycles.

// File: rtl/pcie_lw_pkg.sv
package pcie_lw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROBE_REQ, ST_PROBE_RSP,
    ST_RD1_REQ,   ST_RD1_RSP,
    ST_SET_REQ,   ST_SET_RSP,
    ST_RD2_REQ,   ST_RD2_RSP,
    ST_CLR_REQ,   ST_CLR_RSP
  } lw_state_e;
endpackage

// File: rtl/lw_link_qual.sv
module lw_link_qual #(
  parameter int DBG_W     = 32,
  parameter int UP_BIT    = 4,
  parameter int TRAIN_BIT = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DBG_W-1:0] dbg1,
  output logic             link_up
);
  logic word_unused;
  assign word_unused = ^dbg1;

  always_ff @(posedge clk) begin
    if (!rst_n) link_up <= 1'b0;
    else        link_up <= dbg1[UP_BIT] & ~dbg1[TRAIN_BIT];
  end
endmodule

// File: rtl/lw_probe_timer.sv
module lw_probe_timer #(
  parameter int WAIT_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == CNT_W'(WAIT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expire) cnt <= '0;
    else                          cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/lw_recover_fsm.sv
module lw_recover_fsm
  import pcie_lw_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                LTSSM_W   = 6,
  parameter logic [LTSSM_W-1:0] RCVR_LOCK = 6'h0D,
  parameter logic [ADDR_W-1:0]  RV_ADDR   = 16'h100D,
  parameter logic [ADDR_W-1:0]  OVR_ADDR  = 16'h1005,
  parameter logic [DATA_W-1:0]  OVR_MASK  = 16'h0028
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LTSSM_W-1:0] ltssm,
  output logic               idle,
  output logic               stuck_pulse,
  output logic               err_flag,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [DATA_W-1:0]  rsp_data,
  input  logic               rsp_err
);
  lw_state_e   state, nxt;
  logic [DATA_W-1:0] hold;
  logic        rsp_take, stall_hit;

  assign idle      = (state == ST_IDLE);
  assign rsp_take  = rsp_ready && rsp_valid;
  assign stall_hit = (ltssm == RCVR_LOCK) && (rsp_data == '0);

  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = OVR_ADDR;
    req_wdata = '0;
    rsp_ready = 1'b0;
    case (state)
      ST_PROBE_REQ: begin req_valid = 1'b1; req_addr = RV_ADDR; end
      ST_RD1_REQ, ST_RD2_REQ: req_valid = 1'b1;
      ST_SET_REQ: begin req_valid = 1'b1; req_write = 1'b1; req_wdata = hold | OVR_MASK; end
      ST_CLR_REQ: begin req_valid = 1'b1; req_write = 1'b1; req_wdata = hold & ~OVR_MASK; end
      ST_PROBE_RSP, ST_RD1_RSP, ST_SET_RSP, ST_RD2_RSP, ST_CLR_RSP: rsp_ready = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:      if (start) nxt = ST_PROBE_REQ;
      ST_PROBE_REQ: if (req_ready) nxt = ST_PROBE_RSP;
      ST_RD1_REQ:   if (req_ready) nxt = ST_RD1_RSP;
      ST_SET_REQ:   if (req_ready) nxt = ST_SET_RSP;
      ST_RD2_REQ:   if (req_ready) nxt = ST_RD2_RSP;
      ST_CLR_REQ:   if (req_ready) nxt = ST_CLR_RSP;
      ST_PROBE_RSP: if (rsp_valid) nxt = (!rsp_err && stall_hit) ? ST_RD1_REQ : ST_IDLE;
      ST_RD1_RSP:   if (rsp_valid) nxt = rsp_err ? ST_IDLE : ST_SET_REQ;
      ST_SET_RSP:   if (rsp_valid) nxt = rsp_err ? ST_IDLE : ST_RD2_REQ;
      ST_RD2_RSP:   if (rsp_valid) nxt = rsp_err ? ST_IDLE : ST_CLR_REQ;
      ST_CLR_RSP:   if (rsp_valid) nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      hold        <= '0;
      stuck_pulse <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      state       <= nxt;
      stuck_pulse <= (state == ST_PROBE_RSP) && rsp_take && !rsp_err && stall_hit;
      if (rsp_take && rsp_err) err_flag <= 1'b1;
      if (rsp_take && (state == ST_RD1_RSP || state == ST_RD2_RSP)) hold <= rsp_data;
    end
  end
endmodule

// File: rtl/pcie_link_watch.sv
module pcie_link_watch #(
  parameter int                 DBG_W       = 32,
  parameter int                 LTSSM_W     = 6,
  parameter int                 ADDR_W      = 16,
  parameter int                 DATA_W      = 16,
  parameter int                 UP_BIT      = 4,
  parameter int                 TRAIN_BIT   = 29,
  parameter int                 WAIT_CYCLES = 250000,
  parameter logic [LTSSM_W-1:0] RCVR_LOCK   = 6'h0D,
  parameter logic [ADDR_W-1:0]  RV_ADDR     = 16'h100D,
  parameter logic [ADDR_W-1:0]  OVR_ADDR    = 16'h1005,
  parameter logic [DATA_W-1:0]  OVR_MASK    = 16'h0028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DBG_W-1:0]  dbg_word0,
  input  logic [DBG_W-1:0]  dbg_word1,
  output logic              link_up,
  output logic              stuck_pulse,
  output logic              err_flag,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err
);
  logic seq_idle, probe_due, ltssm_unused;
  assign ltssm_unused = ^dbg_word0;

  lw_link_qual #(.DBG_W(DBG_W), .UP_BIT(UP_BIT), .TRAIN_BIT(TRAIN_BIT)) u_qual (
    .clk(clk), .rst_n(rst_n), .dbg1(dbg_word1), .link_up(link_up)
  );

  lw_probe_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(!link_up && seq_idle), .expire(probe_due)
  );

  lw_recover_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LTSSM_W(LTSSM_W), .RCVR_LOCK(RCVR_LOCK),
    .RV_ADDR(RV_ADDR), .OVR_ADDR(OVR_ADDR), .OVR_MASK(OVR_MASK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(probe_due), .ltssm(dbg_word0[LTSSM_W-1:0]),
    .idle(seq_idle), .stuck_pulse(stuck_pulse), .err_flag(err_flag),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );
endmodule

// File: rtl/lw_checker.sv
module lw_checker #(
  parameter int                DBG_W     = 32,
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                UP_BIT    = 4,
  parameter int                TRAIN_BIT = 29,
  parameter logic [ADDR_W-1:0] RV_ADDR   = 16'h100D,
  parameter logic [ADDR_W-1:0] OVR_ADDR  = 16'h1005
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DBG_W-1:0]  dbg_word1,
  input logic              link_up,
  input logic              stuck_pulse,
  input logic              err_flag,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_ready
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  link_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (link_up == $past(dbg_word1[UP_BIT] && !dbg_word1[TRAIN_BIT])));

  // R2
  probe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_addr == RV_ADDR) |-> $past(!link_up));

  // R6
  stuck_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_pulse |=> !stuck_pulse);

  // R6
  stuck_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_pulse |-> (req_valid && !req_write && req_addr == OVR_ADDR));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));
endmodule

bind pcie_link_watch lw_checker #(
  .DBG_W(DBG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UP_BIT(UP_BIT),
  .TRAIN_BIT(TRAIN_BIT), .RV_ADDR(RV_ADDR), .OVR_ADDR(OVR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_word1(dbg_word1), .link_up(link_up),
  .stuck_pulse(stuck_pulse), .err_flag(err_flag), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_ready(rsp_ready)
);

// File: tb/pcie_link_watch_test.sv
module pcie_link_watch_test;
  localparam int WAIT = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] dbg_word0, dbg_word1;
  logic        link_up, stuck_pulse, err_flag;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [15:0] rsp_data;

  always #5 clk = ~clk;

  pcie_link_watch #(.WAIT_CYCLES(WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .dbg_word0(dbg_word0), .dbg_word1(dbg_word1),
    .link_up(link_up), .stuck_pulse(stuck_pulse), .err_flag(err_flag),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  typedef struct {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic        err;
    string       req;
  } exp_t;

  exp_t        q[$];
  int          n_checks = 0, n_fail = 0;
  int          stuck_seen = 0, stuck_exp = 0;
  int          bp_cycles = 0;
  logic [15:0] rv_val = 16'h0000, ovr_val = 16'h0041;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic wr, input logic [15:0] addr, input logic [15:0] wd,
                      input logic err, input string req);
    exp_t e;
    e.wr = wr; e.addr = addr; e.wdata = wd; e.err = err; e.req = req;
    q.push_back(e);
  endtask

  // Port engine model and scoreboard monitor
  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        logic        c_wr;
        logic [15:0] c_addr, c_wd, d;
        exp_t        e;
        c_addr = req_addr;
        repeat (bp_cycles) @(negedge clk);
        chk(req_valid && req_addr == c_addr, "R8", "request held under back-pressure",
            {16'h0, req_addr}, {16'h0, c_addr});
        req_ready = 1'b1;
        c_wr = req_write; c_addr = req_addr; c_wd = req_wdata;
        @(negedge clk);
        req_ready = 1'b0;
        if (q.size() == 0) begin
          chk(1'b0, "R4", "unexpected access", {15'h0, c_wr, c_addr}, 32'h0);
          e.err = 1'b0;
        end else begin
          e = q.pop_front();
          chk(c_wr == e.wr && c_addr == e.addr, e.req, "access kind/address",
              {15'h0, c_wr, c_addr}, {15'h0, e.wr, e.addr});
          if (e.wr) chk(c_wd == e.wdata, e.req, "write data", {16'h0, c_wd}, {16'h0, e.wdata});
        end
        d = '0;
        if (!c_wr) d = (c_addr == 16'h100D) ? rv_val : (c_addr == 16'h1005) ? ovr_val : 16'h0;
        else if (c_addr == 16'h1005 && !e.err) ovr_val = c_wd;
        chk(rsp_ready && !req_valid, "R8", "rsp_ready while awaiting", {31'h0, rsp_ready}, 32'h1);
        rsp_valid = 1'b1; rsp_err = e.err; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
      end
    end
  end

  // Stuck pulse monitor
  logic stuck_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && stuck_pulse) begin
      stuck_seen++;
      chk(!stuck_prev, "R6", "pulse longer than one cycle", 32'h1, 32'h0);
      chk(req_valid && !req_write && req_addr == 16'h1005, "R6", "pulse aligned to first override read",
          {16'h0, req_addr}, 32'h1005);
    end
    stuck_prev = rst_n && stuck_pulse;
  end

  task automatic go_down_and_time(input string req);
    int n;
    @(negedge clk);
    dbg_word1 = 32'h0000_0000;
    @(negedge clk);
    chk(link_up == 1'b0, "R1", "link drops when bit 4 clear", {31'h0, link_up}, 32'h0);
    n = 0;
    while (!req_valid && n < 4 * WAIT) begin
      @(negedge clk);
      n++;
    end
    chk(n == WAIT, req, "probe delay after link drop", n, WAIT);
  endtask

  task automatic finish_scenario();
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    dbg_word1 = 32'h0000_0010;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; dbg_word0 = '0; dbg_word1 = '0;
    repeat (3) @(negedge clk);
    // R9
    chk(!link_up && !stuck_pulse && !err_flag && !req_valid && !rsp_ready, "R9", "reset state",
        {27'h0, link_up, stuck_pulse, err_flag, req_valid, rsp_ready}, 32'h0);
    rst_n = 1'b1;
    dbg_word1 = 32'h0000_0010;
    @(negedge clk);
    chk(link_up == 1'b1, "R1", "up with bit4 set, bit29 clear", {31'h0, link_up}, 32'h1);
    dbg_word1 = 32'h2000_0010;
    @(negedge clk);
    chk(link_up == 1'b0, "R1", "down while training bit set", {31'h0, link_up}, 32'h0);
    dbg_word1 = 32'hFFFF_FFEF;
    @(negedge clk);
    chk(link_up == 1'b0, "R1", "down with bit4 clear", {31'h0, link_up}, 32'h0);
    dbg_word1 = 32'hDFFF_FFFF;
    @(negedge clk);
    chk(link_up == 1'b1, "R1", "up with other bits noisy", {31'h0, link_up}, 32'h1);
    repeat (3 * WAIT) @(negedge clk);
    chk(q.size() == 0 && !req_valid, "R2", "no probe while link up", {31'h0, req_valid}, 32'h0);

    // Stall detected: full recovery (R3, R4, R5, R6)
    dbg_word0 = 32'h5A5A_A04D;
    rv_val = 16'h0000; ovr_val = 16'h0041;
    bp_cycles = 2;
    push(1'b0, 16'h100D, 16'h0, 1'b0, "R3");
    push(1'b0, 16'h1005, 16'h0, 1'b0, "R5");
    push(1'b1, 16'h1005, 16'h0069, 1'b0, "R5");
    push(1'b0, 16'h1005, 16'h0, 1'b0, "R5");
    push(1'b1, 16'h1005, 16'h0041, 1'b0, "R5");
    stuck_exp++;
    go_down_and_time("R2");
    finish_scenario();
    chk(ovr_val == 16'h0041, "R5", "override bits restored", {16'h0, ovr_val}, 32'h0041);
    chk(stuck_seen == stuck_exp, "R6", "stuck pulse count", stuck_seen, stuck_exp);

    // Receive valid nonzero: probe only, repeats (R4, R10)
    bp_cycles = 0;
    rv_val = 16'h0001;
    push(1'b0, 16'h100D, 16'h0, 1'b0, "R4");
    push(1'b0, 16'h100D, 16'h0, 1'b0, "R10");
    go_down_and_time("R2");
    finish_scenario();
    chk(stuck_seen == stuck_exp, "R4", "no recovery with receive valid set", stuck_seen, stuck_exp);

    // Other LTSSM state: probe only (R4)
    rv_val = 16'h0000;
    dbg_word0 = 32'h0000_0011;
    push(1'b0, 16'h100D, 16'h0, 1'b0, "R4");
    go_down_and_time("R2");
    finish_scenario();
    chk(stuck_seen == stuck_exp, "R4", "no recovery in other state", stuck_seen, stuck_exp);
    chk(err_flag == 1'b0, "R7", "no error yet", {31'h0, err_flag}, 32'h0);

    // Error mid-sequence: abort (R7)
    dbg_word0 = 32'h0000_000D;
    ovr_val = 16'h0100;
    bp_cycles = 1;
    push(1'b0, 16'h100D, 16'h0, 1'b0, "R7");
    push(1'b0, 16'h1005, 16'h0, 1'b1, "R7");
    stuck_exp++;
    go_down_and_time("R2");
    finish_scenario();
    chk(err_flag == 1'b1, "R7", "error flag set", {31'h0, err_flag}, 32'h1);
    chk(ovr_val == 16'h0100, "R7", "no write after error", {16'h0, ovr_val}, 32'h0100);
    chk(stuck_seen == stuck_exp, "R6", "stuck pulse count after abort", stuck_seen, stuck_exp);
    repeat (2 * WAIT) @(negedge clk);
    chk(err_flag == 1'b1, "R7", "error flag sticky", {31'h0, err_flag}, 32'h1);
    chk(q.size() == 0 && !req_valid, "R2", "quiet after link restored", {31'h0, req_valid}, 32'h0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule